// File: doc/BRIEF.md
# Dual-Clock Activation and Usage Metering Unit

This unit connects a licensing controller to a protected core when the two run on unrelated clocks. The controller talks to it over two 32-bit AXI4-Stream channels. On the command channel the controller sends command words, and some of those are followed by data words. On the response channel the unit returns results. Through these commands the controller can do three things: assemble a 128-bit activation code, fetch the current value of a 64-bit usage counter, and clear that counter when a session ends.

On the core side, the unit drives the activation code in the core clock domain. It also counts the clock cycles in which the core holds its usage-event input high.

Every exchange between the two domains uses a toggle-based request/acknowledge handshake. The sending side holds its payload steady until the handshake completes. While a crossing is in flight, the command channel stalls, so no command is ever lost. Each domain has its own active-low asynchronous reset.

Top module: `act_meter_unit`

## Requirements
- R1: After reset, `act_code` is all zeros, `rsp_tvalid` is low, the usage counter reads back as zero, and `cmd_tready` is high once the first handshake-free cycle is reached.
- R2: The opcode is held in bits [31:28] of a command word. Value 0x1 means "load code word", 0x2 means "read counter" and 0x3 means "close session". The unit consumes any other opcode and ignores it: it produces no response beat and leaves both the code and the counter unchanged. A data beat that follows a load command is never decoded as a command.
- R3: Each load command is followed by one data beat carrying 32 code bits. Four such pairs build the 128-bit code, least significant word first (the first beat lands in bits [31:0]). After only three pairs, `act_code` still shows its previous value.
- R4: `act_code` changes only when a complete four-word code is applied. The change happens in the core clock domain, a bounded number of core cycles after the fourth data beat is accepted.
- R5: The counter increases by exactly one on every core clock edge at which `usage_evt` is high. It does not change when `usage_evt` is low.
- R6: A read command returns the counter value as two response beats, bits [31:0] first and then bits [63:32].
- R7: While `rsp_tvalid` is high and `rsp_tready` is low, `rsp_tvalid` stays high and `rsp_tdata` does not change.
- R8: A close command sets the counter to zero. If a clear and a usage event arrive in the same core cycle, the clear wins.
- R9: `cmd_tready` stays low while a crossing handshake is outstanding. Commands issued back to back are all executed in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Controller-side clock |
| bus_rst_n | input | 1 | Controller-side reset, active low, asynchronous |
| cmd_tvalid | input | 1 | Command stream valid |
| cmd_tready | output | 1 | Command stream ready |
| cmd_tdata | input | 32 | Command or data word |
| rsp_tvalid | output | 1 | Response stream valid |
| rsp_tready | input | 1 | Response stream ready |
| rsp_tdata | output | 32 | Response word |
| core_clk | input | 1 | Protected-core clock |
| core_rst_n | input | 1 | Core-side reset, active low, asynchronous |
| usage_evt | input | 1 | Level usage event, core clock |
| act_code | output | 128 | Activation code, core clock |

## Verification
The results are due at different times:

- **Usage events** change the counter at the very next core edge.
- **A completed code load** reaches `act_code` roughly four core cycles after the fourth data beat, once synchronisation is counted.
- **A read** produces its first response beat after a full round trip: about three core cycles plus three bus cycles.

Because the two clocks drift against each other, the bench does not look for the code at a fixed cycle. It polls `act_code` inside a bounded window, and it checks that the value has not changed after a wait well longer than that window. Response words are matched in order through a queue of expected words rather than at fixed cycles, while the single-cycle counter step and the stall of `cmd_tready` are checked at exact edges.

// File: rtl/amu_pkg.sv
`timescale 1ns/1ps
package amu_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_READ  = 4'h2;
  localparam logic [OPC_W-1:0] OPC_CLOSE = 4'h3;

  localparam int KIND_W = 2;
  localparam logic [KIND_W-1:0] XK_NONE  = 2'd0;
  localparam logic [KIND_W-1:0] XK_CODE  = 2'd1;
  localparam logic [KIND_W-1:0] XK_CLEAR = 2'd2;
  localparam logic [KIND_W-1:0] XK_SNAP  = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_SNAP,
    ST_RESP
  } bus_state_e;
endpackage

// File: rtl/amu_hs_xfer.sv
`timescale 1ns/1ps
module amu_hs_xfer #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic         src_send,
  input  logic [W-1:0] src_data,
  output logic         src_busy,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic         dst_valid,
  output logic [W-1:0] dst_data
);
  logic            req_t;
  logic [W-1:0]    hold_q;
  logic [SYNC-1:0] req_sync;
  logic            req_seen;
  logic [SYNC-1:0] ack_sync;

  // source side: flip the request and freeze the payload
  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      req_t  <= 1'b0;
      hold_q <= '0;
    end else if (src_send && !src_busy) begin
      req_t  <= ~req_t;
      hold_q <= src_data;
    end
  end

  // destination side: synchronise request, detect a change
  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      req_sync <= '0;
      req_seen <= 1'b0;
    end else begin
      req_sync <= {req_sync[SYNC-2:0], req_t};
      req_seen <= req_sync[SYNC-1];
    end
  end

  assign dst_valid = req_sync[SYNC-1] ^ req_seen;
  assign dst_data  = hold_q;

  // acknowledge returns as the seen level
  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) ack_sync <= '0;
    else            ack_sync <= {ack_sync[SYNC-2:0], req_seen};
  end

  assign src_busy = req_t ^ ack_sync[SYNC-1];
endmodule

// File: rtl/amu_bus_ctrl.sv
`timescale 1ns/1ps
module amu_bus_ctrl
  import amu_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int CODE_W = 128,
  parameter int CNT_W  = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_tvalid,
  output logic                     cmd_tready,
  input  logic [BUS_W-1:0]         cmd_tdata,
  output logic                     rsp_tvalid,
  input  logic                     rsp_tready,
  output logic [BUS_W-1:0]         rsp_tdata,
  output logic                     down_send,
  output logic [CODE_W+KIND_W-1:0] down_data,
  input  logic                     down_busy,
  input  logic                     up_valid,
  input  logic [CNT_W-1:0]         up_data
);
  localparam int CODE_WORDS = CODE_W / BUS_W;
  localparam int CNT_WORDS  = CNT_W / BUS_W;
  localparam int WI_W = (CODE_WORDS > 1) ? $clog2(CODE_WORDS) : 1;
  localparam int RI_W = (CNT_WORDS > 1) ? $clog2(CNT_WORDS) : 1;
  localparam logic [WI_W-1:0] W_LAST = WI_W'(CODE_WORDS - 1);
  localparam logic [RI_W-1:0] R_LAST = RI_W'(CNT_WORDS - 1);

  function automatic logic [CODE_W-1:0] put_word(input logic [CODE_W-1:0] base,
                                                 input logic [WI_W-1:0] idx,
                                                 input logic [BUS_W-1:0] w);
    logic [CODE_W-1:0] r;
    r = base;
    r[idx*BUS_W +: BUS_W] = w;
    return r;
  endfunction

  function automatic logic [BUS_W-1:0] pick_word(input logic [CNT_W-1:0] v,
                                                 input logic [RI_W-1:0] idx);
    return v[idx*BUS_W +: BUS_W];
  endfunction

  bus_state_e        st;
  logic [CODE_W-1:0] shadow;
  logic [WI_W-1:0]   widx;
  logic [CNT_W-1:0]  snap_q;
  logic [RI_W-1:0]   ridx;
  logic [CODE_W-1:0] merged;
  logic [OPC_W-1:0]  opc;
  logic              accept;

  assign cmd_tready = ((st == ST_IDLE) || (st == ST_DATA)) && !down_busy;
  assign accept     = cmd_tvalid && cmd_tready;
  assign opc        = cmd_tdata[BUS_W-1 -: OPC_W];
  assign merged     = put_word(shadow, widx, cmd_tdata);
  assign rsp_tvalid = (st == ST_RESP);
  assign rsp_tdata  = pick_word(snap_q, ridx);

  always_comb begin
    down_send = 1'b0;
    down_data = {XK_NONE, shadow};
    if (accept && (st == ST_IDLE) && (opc == OPC_READ)) begin
      down_send = 1'b1;
      down_data = {XK_SNAP, shadow};
    end else if (accept && (st == ST_IDLE) && (opc == OPC_CLOSE)) begin
      down_send = 1'b1;
      down_data = {XK_CLEAR, shadow};
    end else if (accept && (st == ST_DATA) && (widx == W_LAST)) begin
      down_send = 1'b1;
      down_data = {XK_CODE, merged};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      shadow <= '0;
      widx   <= '0;
      snap_q <= '0;
      ridx   <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept) begin
            if (opc == OPC_LOAD)      st <= ST_DATA;
            else if (opc == OPC_READ) st <= ST_SNAP;
          end
        end
        ST_DATA: begin
          if (accept) begin
            shadow <= merged;
            widx   <= (widx == W_LAST) ? '0 : widx + 1'b1;
            st     <= ST_IDLE;
          end
        end
        ST_SNAP: begin
          if (up_valid) begin
            snap_q <= up_data;
            ridx   <= '0;
            st     <= ST_RESP;
          end
        end
        default: begin
          if (rsp_tready) begin
            if (ridx == R_LAST) st <= ST_IDLE;
            else                ridx <= ridx + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/amu_core_side.sv
`timescale 1ns/1ps
module amu_core_side
  import amu_pkg::*;
#(
  parameter int CODE_W = 128,
  parameter int CNT_W  = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     usage_evt,
  input  logic                     in_valid,
  input  logic [CODE_W+KIND_W-1:0] in_data,
  output logic [CODE_W-1:0]        act_code,
  output logic [CNT_W-1:0]         usage_cnt,
  output logic                     code_apply,
  output logic                     clear_hit,
  output logic                     up_send,
  output logic [CNT_W-1:0]         up_data,
  input  logic                     up_busy
);
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic evt,
                                                  input logic clr);
    if (clr) return '0;
    if (evt) return c + CNT_W'(1);
    return c;
  endfunction

  logic [KIND_W-1:0] kind;
  logic              snap_req;
  logic              snap_pend;

  assign kind       = in_data[CODE_W +: KIND_W];
  assign code_apply = in_valid && (kind == XK_CODE);
  assign clear_hit  = in_valid && (kind == XK_CLEAR);
  assign snap_req   = in_valid && (kind == XK_SNAP);
  assign up_send    = snap_req || snap_pend;
  assign up_data    = usage_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_code  <= '0;
      usage_cnt <= '0;
      snap_pend <= 1'b0;
    end else begin
      if (code_apply) act_code <= in_data[CODE_W-1:0];
      usage_cnt <= next_count(usage_cnt, usage_evt, clear_hit);
      snap_pend <= up_send && up_busy;
    end
  end
endmodule

// File: rtl/act_meter_unit.sv
`timescale 1ns/1ps
module act_meter_unit
  import amu_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int CODE_W = 128,
  parameter int CNT_W  = 64,
  parameter int SYNC   = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              cmd_tvalid,
  output logic              cmd_tready,
  input  logic [BUS_W-1:0]  cmd_tdata,
  output logic              rsp_tvalid,
  input  logic              rsp_tready,
  output logic [BUS_W-1:0]  rsp_tdata,
  input  logic              core_clk,
  input  logic              core_rst_n,
  input  logic              usage_evt,
  output logic [CODE_W-1:0] act_code
);
  localparam int DOWN_W = CODE_W + KIND_W;

  logic              down_send;
  logic [DOWN_W-1:0] down_data;
  logic              down_busy;
  logic              down_valid;
  logic [DOWN_W-1:0] down_rx;
  logic              up_send;
  logic [CNT_W-1:0]  up_data;
  logic              up_busy;
  logic              up_valid;
  logic [CNT_W-1:0]  up_rx;
  logic [CNT_W-1:0]  usage_cnt;
  logic              code_apply;
  logic              clear_hit;

  amu_bus_ctrl #(.BUS_W(BUS_W), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_bus (
    .clk(bus_clk), .rst_n(bus_rst_n),
    .cmd_tvalid(cmd_tvalid), .cmd_tready(cmd_tready), .cmd_tdata(cmd_tdata),
    .rsp_tvalid(rsp_tvalid), .rsp_tready(rsp_tready), .rsp_tdata(rsp_tdata),
    .down_send(down_send), .down_data(down_data), .down_busy(down_busy),
    .up_valid(up_valid), .up_data(up_rx)
  );

  amu_hs_xfer #(.W(DOWN_W), .SYNC(SYNC)) u_down (
    .src_clk(bus_clk), .src_rst_n(bus_rst_n),
    .src_send(down_send), .src_data(down_data), .src_busy(down_busy),
    .dst_clk(core_clk), .dst_rst_n(core_rst_n),
    .dst_valid(down_valid), .dst_data(down_rx)
  );

  amu_core_side #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_core (
    .clk(core_clk), .rst_n(core_rst_n), .usage_evt(usage_evt),
    .in_valid(down_valid), .in_data(down_rx),
    .act_code(act_code), .usage_cnt(usage_cnt),
    .code_apply(code_apply), .clear_hit(clear_hit),
    .up_send(up_send), .up_data(up_data), .up_busy(up_busy)
  );

  amu_hs_xfer #(.W(CNT_W), .SYNC(SYNC)) u_up (
    .src_clk(core_clk), .src_rst_n(core_rst_n),
    .src_send(up_send), .src_data(up_data), .src_busy(up_busy),
    .dst_clk(bus_clk), .dst_rst_n(bus_rst_n),
    .dst_valid(up_valid), .dst_data(up_rx)
  );
endmodule

// File: rtl/amu_checker.sv
`timescale 1ns/1ps
module amu_checker #(
  parameter int BUS_W  = 32,
  parameter int CODE_W = 128,
  parameter int CNT_W  = 64
) (
  input logic              bus_clk,
  input logic              bus_rst_n,
  input logic              core_clk,
  input logic              core_rst_n,
  input logic              cmd_tready,
  input logic              rsp_tvalid,
  input logic              rsp_tready,
  input logic [BUS_W-1:0]  rsp_tdata,
  input logic              usage_evt,
  input logic [CODE_W-1:0] act_code,
  input logic [CNT_W-1:0]  usage_cnt,
  input logic              code_apply,
  input logic              clear_hit,
  input logic              down_busy
);
  // R7
  rsp_hold_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (rsp_tvalid && !rsp_tready) |=> (rsp_tvalid && $stable(rsp_tdata)));

  // R9
  busy_stall_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    down_busy |-> !cmd_tready);

  // R4
  code_gate_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    !code_apply |=> $stable(act_code));

  // R8
  clear_wins_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    clear_hit |=> (usage_cnt == '0));

  // R5
  count_step_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    (usage_evt && !clear_hit) |=> ((usage_cnt - $past(usage_cnt)) == CNT_W'(1)));

  // R5
  count_idle_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    (!usage_evt && !clear_hit) |=> $stable(usage_cnt));
endmodule

bind act_meter_unit amu_checker #(.BUS_W(BUS_W), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
  .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .core_clk(core_clk), .core_rst_n(core_rst_n),
  .cmd_tready(cmd_tready), .rsp_tvalid(rsp_tvalid), .rsp_tready(rsp_tready),
  .rsp_tdata(rsp_tdata), .usage_evt(usage_evt), .act_code(act_code),
  .usage_cnt(usage_cnt), .code_apply(code_apply), .clear_hit(clear_hit),
  .down_busy(down_busy)
);

// File: tb/test_act_meter_unit.sv
`timescale 1ns/1ps
module test_act_meter_unit;
  logic         bus_clk = 1'b0;
  logic         core_clk = 1'b0;
  logic         bus_rst_n = 1'b0;
  logic         core_rst_n = 1'b0;
  logic         cmd_tvalid = 1'b0;
  logic         cmd_tready;
  logic [31:0]  cmd_tdata = '0;
  logic         rsp_tvalid;
  logic         rsp_tready = 1'b1;
  logic [31:0]  rsp_tdata;
  logic         usage_evt = 1'b0;
  logic [127:0] act_code;

  always #2 bus_clk = ~bus_clk;     // 250 MHz
  always #3.5 core_clk = ~core_clk; // unrelated core clock

  act_meter_unit i_act_meter_unit (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
    .cmd_tvalid(cmd_tvalid), .cmd_tready(cmd_tready), .cmd_tdata(cmd_tdata),
    .rsp_tvalid(rsp_tvalid), .rsp_tready(rsp_tready), .rsp_tdata(rsp_tdata),
    .core_clk(core_clk), .core_rst_n(core_rst_n),
    .usage_evt(usage_evt), .act_code(act_code)
  );

  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;
  logic [31:0] exp_q[$];
  string       req_q[$];
  logic [63:0] exp_cnt = '0;
  logic [127:0] exp_code = '0;

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: a beat is accepted at the posedge after this negedge
  initial begin
    forever begin
      @(negedge bus_clk);
      if (rsp_tvalid && rsp_tready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected response beat", {96'd0, rsp_tdata}, '0);
        end else begin
          logic [31:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check(rsp_tdata == e, r, {96'd0, rsp_tdata}, {96'd0, e});
        end
      end
    end
  end

  task automatic send_word(input logic [31:0] w);
    @(negedge bus_clk);
    cmd_tvalid = 1'b1;
    cmd_tdata  = w;
    while (!cmd_tready) @(negedge bus_clk);
    @(negedge bus_clk);
    cmd_tvalid = 1'b0;
  endtask

  task automatic expect_count(input string req);
    exp_q.push_back(exp_cnt[31:0]);  req_q.push_back(req);
    exp_q.push_back(exp_cnt[63:32]); req_q.push_back(req);
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge bus_clk);
    check(exp_q.size() == 0, "R6 response beats missing", exp_q.size(), 0);
  endtask

  task automatic read_count(input string req);
    expect_count(req);
    send_word(32'h2000_0000);
    drain();
  endtask

  task automatic pulses(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge core_clk); usage_evt = 1'b1;
      @(negedge core_clk); usage_evt = 1'b0;
      repeat (gap) @(negedge core_clk);
    end
    exp_cnt += 64'(n);
  endtask

  task automatic burst(input int n);
    @(negedge core_clk); usage_evt = 1'b1;
    repeat (n) @(negedge core_clk);
    usage_evt = 1'b0;
    exp_cnt += 64'(n);
  endtask

  task automatic load_words(input logic [127:0] c, input int first, input int last);
    for (int i = first; i <= last; i++) begin
      send_word(32'h1000_0000);
      send_word(c[i*32 +: 32]);
    end
  endtask

  task automatic wait_code(input logic [127:0] c, input string req);
    for (int i = 0; i < 60 && act_code != c; i++) @(negedge core_clk);
    check(act_code == c, req, act_code, c);
  endtask

  initial begin
    repeat (6) @(negedge bus_clk);
    bus_rst_n = 1'b1;
    core_rst_n = 1'b1;
    repeat (4) @(negedge bus_clk);
    // R1 reset state
    check(act_code == '0, "R1 code after reset", act_code, '0);
    check(rsp_tvalid == 1'b0, "R1 rsp_tvalid after reset", rsp_tvalid, 0);
    check(cmd_tready == 1'b1, "R1 cmd_tready after reset", cmd_tready, 1);
    read_count("R1 counter after reset");

    // R5 counting under spaced pulses and a burst
    pulses(5, 2);
    burst(17);
    pulses(3, 0);
    read_count("R5 count after mixed events");

    // R3 partial load holds the old code; R4 full load applies it
    exp_code = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
    load_words(exp_code, 0, 2);
    repeat (40) @(negedge core_clk);
    check(act_code == '0, "R3 code held after three words", act_code, '0);
    load_words(exp_code, 3, 3);
    wait_code(exp_code, "R4 code after four words");

    // R3 word order, one word looks like a close command
    exp_code = 128'hDEAD_BEEF_3000_0000_0BAD_F00D_CAFE_0001;
    load_words(exp_code, 0, 3);
    wait_code(exp_code, "R3 word order low first");
    read_count("R2 data beat not decoded as close");

    // R2 unknown opcodes ignored
    send_word(32'h7000_0001);
    send_word(32'h0000_0003);
    send_word(32'hF123_4567);
    read_count("R2 count after unknown opcodes");
    check(act_code == exp_code, "R2 code after unknown opcodes", act_code, exp_code);

    // R9 stall during handshake, R8 clear
    send_word(32'h3000_0000);
    check(cmd_tready == 1'b0, "R9 ready low while crossing", cmd_tready, 0);
    exp_cnt = '0;
    read_count("R8 count after close");

    // R9 back-to-back: events, close, read, load with no gaps
    pulses(4, 1);
    send_word(32'h3000_0000);
    exp_cnt = '0;
    expect_count("R9 read right after close");
    send_word(32'h2000_0000);
    drain();
    pulses(9, 1);
    read_count("R8 count restarts after close");

    // R7 back-pressure on the response stream
    @(posedge bus_clk); #1 rsp_tready = 1'b0;
    send_word(32'h2000_0000);
    for (int i = 0; i < 100 && !rsp_tvalid; i++) @(negedge bus_clk);
    begin
      logic [31:0] held;
      held = rsp_tdata;
      repeat (6) @(negedge bus_clk);
      check(rsp_tvalid == 1'b1, "R7 valid held under back-pressure", rsp_tvalid, 1);
      check(rsp_tdata == held, "R7 data held under back-pressure", rsp_tdata, held);
      check(held == exp_cnt[31:0], "R6 first beat is low word", held, exp_cnt[31:0]);
    end
    expect_count("R6 beats after back-pressure");
    @(posedge bus_clk); #1 rsp_tready = 1'b1;
    drain();

    repeat (10) @(negedge bus_clk);
    check(rsp_tvalid == 1'b0, "R2 no stray response", rsp_tvalid, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule